// File: doc/BRIEF.md
# Two-Event Rendezvous State Machine

This block is a small control FSM that waits until two independent events, A and B, have both been observed since the last reset, and then raises a single-cycle output pulse. The events may arrive in either order, with any number of idle cycles between them, or together in the same clock cycle. After the output cycle the machine returns to its idle state on its own and starts waiting for a fresh pair.

The current state is held in a one-hot register and brought out on a port, so that a testbench or an on-chip monitor can follow the machine without decoding. The output flag is registered alongside the state, so both leave the block straight from flops. Reset is asynchronous and active low.

Top module: `pair_arrival_fsm`

## Requirements
- R1: The state port is always exactly one-hot, with waiting-for-both = 4'b0001, have-A = 4'b0010, have-B = 4'b0100 and fire = 4'b1000.
- R2: While rst_n is low the state is 4'b0001 and o_out is 0; the reset acts at once, without waiting for a clock edge.
- R3: In the waiting-for-both state, a clock edge with only a_in high moves to have-A, with only b_in high moves to have-B, and with neither high keeps the state.
- R4: In the waiting-for-both state, a clock edge with a_in and b_in both high moves straight to fire.
- R5: In have-A, a clock edge with b_in high moves to fire; without b_in (including a repeated a_in) the state stays have-A.
- R6: In have-B, a clock edge with a_in high moves to fire; without a_in (including a repeated b_in) the state stays have-B.
- R7: From fire, the next clock edge always moves to waiting-for-both, whatever a_in and b_in are.
- R8: o_out is 1 exactly in the cycles where the state is fire, so it is high only after both events have been seen since the last reset or the last fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | Event A, sampled on each rising edge |
| b_in | input | 1 | Event B, sampled on each rising edge |
| o_out | output | 1 | High for the one cycle spent in the fire state |
| state_o | output | 4 | One-hot current state |

## Verification
The checker watches every cycle for a legal one-hot state, for o_out matching the fire state, for every transition out of each state given the sampled inputs, and for the idle state being held while reset is low. The immediate effect of a reset asserted between clock edges, the two arrival orders separated by long gaps, repeated first events and a long pseudo-random input stream are only shown by the bench scenarios, which compare against a model that tracks which events have been seen rather than which state is held.

// File: rtl/pair_arrival_pkg.sv
package pair_arrival_pkg;
  localparam int unsigned NUM_STATES = 4;
  typedef logic [NUM_STATES-1:0] pa_state_t;

  // R1: one-hot encodings
  localparam pa_state_t ST_WAIT = 4'b0001;
  localparam pa_state_t ST_HAVE_A = 4'b0010;
  localparam pa_state_t ST_HAVE_B = 4'b0100;
  localparam pa_state_t ST_FIRE = 4'b1000;
endpackage

// File: rtl/pair_arrival_next.sv
module pair_arrival_next
  import pair_arrival_pkg::*;
(
  input  pa_state_t cur_state,
  input  logic      ev_a,
  input  logic      ev_b,
  output pa_state_t nxt_state,
  output logic      nxt_fire
);
  always_comb begin
    nxt_state = ST_WAIT;
    unique case (cur_state)
      ST_WAIT: begin
        if (ev_a && ev_b)  nxt_state = ST_FIRE;    // R4
        else if (ev_a)     nxt_state = ST_HAVE_A;  // R3
        else if (ev_b)     nxt_state = ST_HAVE_B;  // R3
        else               nxt_state = ST_WAIT;
      end
      ST_HAVE_A: nxt_state = ev_b ? ST_FIRE : ST_HAVE_A;  // R5
      ST_HAVE_B: nxt_state = ev_a ? ST_FIRE : ST_HAVE_B;  // R6
      ST_FIRE:   nxt_state = ST_WAIT;                     // R7
      default:   nxt_state = ST_WAIT;
    endcase
    nxt_fire = (nxt_state == ST_FIRE);  // R8: registered with the state
  end
endmodule

// File: rtl/pair_arrival_reg.sv
module pair_arrival_reg #(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // R2: asynchronous active-low reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/pair_arrival_fsm.sv
module pair_arrival_fsm
  import pair_arrival_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_in,
  input  logic                  b_in,
  output logic                  o_out,
  output logic [NUM_STATES-1:0] state_o
);
  localparam int unsigned REG_W = NUM_STATES + 1;
  localparam logic [REG_W-1:0] REG_RST = {1'b0, ST_WAIT};

  pa_state_t        cur_q;
  pa_state_t        nxt_d;
  logic             fire_d;
  logic [REG_W-1:0] reg_q;

  pair_arrival_next u_next (
    .cur_state (cur_q),
    .ev_a      (a_in),
    .ev_b      (b_in),
    .nxt_state (nxt_d),
    .nxt_fire  (fire_d)
  );

  pair_arrival_reg #(.WIDTH(REG_W), .RESET_VAL(REG_RST)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fire_d, nxt_d}),
    .q     (reg_q)
  );

  assign cur_q   = reg_q[NUM_STATES-1:0];
  assign state_o = cur_q;
  assign o_out   = reg_q[REG_W-1];
endmodule

// File: rtl/pair_arrival_chk.sv
module pair_arrival_chk
  import pair_arrival_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  a_in,
  input logic                  b_in,
  input logic                  o_out,
  input logic [NUM_STATES-1:0] state_o
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_o) == 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r2: assert (state_o == ST_WAIT && !o_out);
    end
  end

  p_wait_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT && a_in && !b_in) |=> state_o == ST_HAVE_A);
  p_wait_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT && !a_in && b_in) |=> state_o == ST_HAVE_B);
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT && !a_in && !b_in) |=> state_o == ST_WAIT);
  p_wait_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT && a_in && b_in) |=> state_o == ST_FIRE);
  p_have_a_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HAVE_A && b_in) |=> state_o == ST_FIRE);
  p_have_a_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HAVE_A && !b_in) |=> state_o == ST_HAVE_A);
  p_have_b_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HAVE_B && a_in) |=> state_o == ST_FIRE);
  p_have_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HAVE_B && !a_in) |=> state_o == ST_HAVE_B);
  p_fire_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FIRE) |=> state_o == ST_WAIT);
  p_out_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_out == (state_o == ST_FIRE));
endmodule

bind pair_arrival_fsm pair_arrival_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .o_out   (o_out),
  .state_o (state_o)
);

// File: tb/tb_pair_arrival_fsm.sv
module tb_pair_arrival_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       a_in = 1'b0;
  logic       b_in = 1'b0;
  logic       o_out;
  logic [3:0] state_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference: which events have been seen, plus whether this is the fire cycle
  bit m_seen_a = 0;
  bit m_seen_b = 0;
  bit m_fire = 0;

  always #10 clk = ~clk;  // 50 MHz

  pair_arrival_fsm dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .o_out(o_out), .state_o(state_o)
  );

  function automatic logic [3:0] exp_state();
    if (m_fire)                return 4'b1000;
    if (m_seen_a && !m_seen_b) return 4'b0010;
    if (m_seen_b && !m_seen_a) return 4'b0100;
    return 4'b0001;
  endfunction

  task automatic check(input string tag);
    logic [3:0] es;
    es = exp_state();
    n_checks++;
    if (state_o !== es || o_out !== m_fire) begin
      n_fail++;
      $display("FAIL %s: state=%b o=%b expected state=%b o=%b",
               tag, state_o, o_out, es, m_fire);
    end
  endtask

  function automatic string tag_for(bit a, bit b);
    if (m_fire) return "R7";
    if (!m_seen_a && !m_seen_b) return (a && b) ? "R4" : "R3";
    if (m_seen_a) return "R5";
    return "R6";
  endfunction

  task automatic model_reset();
    m_seen_a = 0; m_seen_b = 0; m_fire = 0;
  endtask

  // drive inputs, take one edge, update model, compare (R1, R8 on every step)
  task automatic step(input bit a, input bit b);
    string t;
    a_in = a; b_in = b;
    t = tag_for(a, b);
    @(posedge clk);
    #2;
    if (m_fire) begin
      model_reset();
    end else begin
      m_seen_a = m_seen_a | a;
      m_seen_b = m_seen_b | b;
      if (m_seen_a && m_seen_b) m_fire = 1;
    end
    check({t, "/R1/R8"});
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 model_reset();
    check("R2 in reset");
    rst_n = 1'b1;
    step(0, 0); step(0, 0);                // R3 hold
    step(1, 0); step(0, 0); step(0, 1);     // R3, R5 order A then B
    step(0, 0);                             // R7
    step(0, 1); step(0, 0); step(0, 0); step(1, 0);  // R6 order B then A
    step(1, 1);                             // R7 with both high
    step(1, 1);                             // R4
    step(0, 0);
    step(1, 0); step(1, 0); step(1, 0); step(0, 1);  // R5 repeated A
    step(0, 0);
    step(0, 1); step(0, 1); step(1, 1);     // R6 repeated B
    step(0, 0);
    // R2: asynchronous reset between edges from have-A
    step(1, 0);
    #3 rst_n = 1'b0;
    #2 model_reset();
    check("R2 async mid-cycle");
    @(posedge clk);
    #2 check("R2 held");
    rst_n = 1'b1;
    // pseudo-random stream
    begin
      logic [7:0] lf = 8'h5A;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(lf[0] & lf[3], lf[1] & lf[6]);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule